// File: doc/BRIEF.md
# Tagged Translation Lookaside Buffer

This block is a small, fully associative cache of address translations. A requester presents a virtual address together with the identifier of the running virtual machine and the identifier of the current address space. One cycle later it gets a registered response. A hit carries the physical address. A miss tells an external table walker to fetch the mapping. The walker writes the mapping back through a refill port. Refills go to slots chosen in round-robin order.

Each entry holds one of two mapping sizes. A page entry translates a 64 KB page. A block entry translates a 512 MB region. The physical address is built from the entry's output bits and the low offset bits of the incoming virtual address. Entries are tagged with both identifiers. An entry marked global ignores the address space identifier, but the virtual machine identifier must still match.

Software maintenance arrives as invalidate commands. A command can clear every entry, or only the entries selected by virtual machine, by virtual machine plus address space, or by virtual machine plus address. Each command takes effect in one cycle and is acknowledged with a done pulse.

Top module: `vtag_tlb`

## Requirements
- R1: After reset every entry is invalid, `rsp_valid_o` and `inv_done_o` are low, and any lookup reports a miss.
- R2: A lookup accepted on a clock edge produces exactly one response on the next edge: `rsp_valid_o` high, with exactly one of `rsp_hit_o` and `rsp_miss_o` high.
- R3: A page entry matches when virtual address bits [VA_W-1:16] are equal. On a hit, `rsp_pa_o` equals the entry's physical bits [PA_W-1:16] joined with virtual address bits [15:0].
- R4: A block entry matches when virtual address bits [VA_W-1:29] are equal. On a hit, `rsp_pa_o` equals the entry's physical bits [PA_W-1:29] joined with virtual address bits [28:0].
- R5: A lookup hits only if the virtual machine identifier of the entry equals `lk_vmid_i`, and this holds for global entries as well.
- R6: A non-global entry hits only if its address space identifier equals `lk_asid_i`. A global entry hits for any `lk_asid_i`.
- R7: Refills write slots 0, 1, …, ENTRIES-1 in turn and then wrap, starting from slot 0 after reset. The refill after ENTRIES refills overwrites the oldest entry.
- R8: Invalidate code 2'b00 clears all entries.
- R9: Invalidate code 2'b01 clears every entry whose virtual machine identifier equals `inv_vmid_i`.
- R10: Invalidate code 2'b10 clears the non-global entries whose virtual machine and address space identifiers both match. Global entries survive it.
- R11: Invalidate code 2'b11 clears entries of the matching virtual machine whose page or block covers `inv_va_i`, compared at that entry's own size.
- R12: `inv_done_o` is high for one cycle, on the edge after each cycle in which `inv_valid_i` is high.
- R13: When a refill and an invalidate fall in the same cycle, the invalidate is applied first. The refilled entry is valid afterwards, even if the invalidate selects it.
- R14: A lookup in the same cycle as a refill or an invalidate is answered from the contents before that cycle's updates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lk_valid_i | input | 1 | Lookup request |
| lk_va_i | input | VA_W | Lookup virtual address |
| lk_vmid_i | input | VMID_W | Requester virtual machine identifier |
| lk_asid_i | input | ASID_W | Requester address space identifier |
| rsp_valid_o | output | 1 | Response valid, one cycle after the request |
| rsp_hit_o | output | 1 | Translation found |
| rsp_miss_o | output | 1 | No translation; walker refill needed |
| rsp_pa_o | output | PA_W | Physical address on hit, zero on miss |
| fill_valid_i | input | 1 | Refill write |
| fill_va_i | input | VA_W | Refill virtual address |
| fill_pa_i | input | PA_W | Refill physical address |
| fill_vmid_i | input | VMID_W | Refill virtual machine identifier |
| fill_asid_i | input | ASID_W | Refill address space identifier |
| fill_block_i | input | 1 | 1: 512 MB block entry, 0: 64 KB page entry |
| fill_global_i | input | 1 | Entry matches any address space identifier |
| inv_valid_i | input | 1 | Invalidate command |
| inv_op_i | input | 2 | Invalidate scope code (see R8 to R11) |
| inv_vmid_i | input | VMID_W | Invalidate virtual machine identifier |
| inv_asid_i | input | ASID_W | Invalidate address space identifier |
| inv_va_i | input | VA_W | Invalidate virtual address |
| inv_done_o | output | 1 | Invalidate completion pulse |

## Verification
Three activities can meet in one cycle: a refill, an invalidate and a lookup. The bench drives a refill together with an invalidate-all, and a refill together with an invalidate by virtual machine whose scope covers the new entry. Later lookups must hit the refilled entry, which shows that the invalidate was applied first. A lookup issued in the same cycle as an invalidate-all must still hit on the old contents, and the next lookup must miss.

// File: rtl/vtlb_pkg.sv
package vtlb_pkg;
  localparam int unsigned PAGE_BITS  = 16;
  localparam int unsigned BLOCK_BITS = 29;

  typedef enum logic [1:0] {
    INV_ALL   = 2'b00,
    INV_VM    = 2'b01,
    INV_VM_AS = 2'b10,
    INV_VM_VA = 2'b11
  } inv_op_e;
endpackage

// File: rtl/vtlb_match.sv
module vtlb_match
  import vtlb_pkg::*;
#(
  parameter int unsigned VA_W   = 48,
  parameter int unsigned VMID_W = 8,
  parameter int unsigned ASID_W = 8
) (
  input  logic [VA_W-1:PAGE_BITS] ent_vpn_i,
  input  logic                    ent_block_i,
  input  logic [VMID_W-1:0]       ent_vmid_i,
  input  logic [ASID_W-1:0]       ent_asid_i,
  input  logic [VA_W-1:0]         q_va_i,
  input  logic [VMID_W-1:0]       q_vmid_i,
  input  logic [ASID_W-1:0]       q_asid_i,
  output logic                    va_hit_o,
  output logic                    vm_hit_o,
  output logic                    as_eq_o
);
  // block entries compare only the bits above the 512 MB offset
  always_comb begin
    if (ent_block_i)
      va_hit_o = ent_vpn_i[VA_W-1:BLOCK_BITS] == q_va_i[VA_W-1:BLOCK_BITS];
    else
      va_hit_o = ent_vpn_i == q_va_i[VA_W-1:PAGE_BITS];
  end

  assign vm_hit_o = ent_vmid_i == q_vmid_i;
  assign as_eq_o  = ent_asid_i == q_asid_i;
endmodule

// File: rtl/vtlb_victim.sv
module vtlb_victim #(
  parameter int unsigned ENTRIES = 4,
  localparam int unsigned IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  output logic [IDX_W-1:0] idx_o
);
  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)
      idx_q <= '0;
    else if (adv_i)
      idx_q <= (idx_q == IDX_W'(ENTRIES - 1)) ? '0 : idx_q + 1'b1;
  end

  assign idx_o = idx_q;

  generate
    if (ENTRIES > 1) begin : g_chk
      AST_VICTIM_ADVANCES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        adv_i |=> idx_q != $past(idx_q)); // R7
      AST_VICTIM_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        idx_q <= IDX_W'(ENTRIES - 1)); // R7
    end
  endgenerate
endmodule

// File: rtl/vtag_tlb.sv
module vtag_tlb
  import vtlb_pkg::*;
#(
  parameter int unsigned ENTRIES = 4,
  parameter int unsigned VA_W    = 48,
  parameter int unsigned PA_W    = 48,
  parameter int unsigned VMID_W  = 8,
  parameter int unsigned ASID_W  = 8,
  localparam int unsigned IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lk_valid_i,
  input  logic [VA_W-1:0]   lk_va_i,
  input  logic [VMID_W-1:0] lk_vmid_i,
  input  logic [ASID_W-1:0] lk_asid_i,
  output logic              rsp_valid_o,
  output logic              rsp_hit_o,
  output logic              rsp_miss_o,
  output logic [PA_W-1:0]   rsp_pa_o,
  input  logic              fill_valid_i,
  input  logic [VA_W-1:0]   fill_va_i,
  input  logic [PA_W-1:0]   fill_pa_i,
  input  logic [VMID_W-1:0] fill_vmid_i,
  input  logic [ASID_W-1:0] fill_asid_i,
  input  logic              fill_block_i,
  input  logic              fill_global_i,
  input  logic              inv_valid_i,
  input  logic [1:0]        inv_op_i,
  input  logic [VMID_W-1:0] inv_vmid_i,
  input  logic [ASID_W-1:0] inv_asid_i,
  input  logic [VA_W-1:0]   inv_va_i,
  output logic              inv_done_o
);
  logic [ENTRIES-1:0]        valid_q, valid_d, block_q, global_q;
  logic [VA_W-1:PAGE_BITS]   vpn_q  [ENTRIES];
  logic [PA_W-1:PAGE_BITS]   ppn_q  [ENTRIES];
  logic [VMID_W-1:0]         vmid_q [ENTRIES];
  logic [ASID_W-1:0]         asid_q [ENTRIES];

  logic [ENTRIES-1:0] lk_hit, inv_kill;
  logic [PA_W-1:0]    pa_cand [ENTRIES];
  logic [PA_W-1:0]    pa_sel;
  logic [IDX_W-1:0]   victim;
  inv_op_e            inv_op;

  logic              rsp_valid_q, rsp_hit_q, rsp_miss_q, inv_done_q;
  logic [PA_W-1:0]   rsp_pa_q;

  assign inv_op = inv_op_e'(inv_op_i);

  vtlb_victim #(.ENTRIES(ENTRIES)) u_victim (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .adv_i  (fill_valid_i),
    .idx_o  (victim)
  );

  generate
    for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
      logic lk_va, lk_vm, lk_as, iv_va, iv_vm, iv_as, sel;

      vtlb_match #(.VA_W(VA_W), .VMID_W(VMID_W), .ASID_W(ASID_W)) u_lk (
        .ent_vpn_i (vpn_q[i]),  .ent_block_i (block_q[i]),
        .ent_vmid_i(vmid_q[i]), .ent_asid_i  (asid_q[i]),
        .q_va_i    (lk_va_i),   .q_vmid_i    (lk_vmid_i), .q_asid_i(lk_asid_i),
        .va_hit_o  (lk_va),     .vm_hit_o    (lk_vm),     .as_eq_o (lk_as)
      );

      vtlb_match #(.VA_W(VA_W), .VMID_W(VMID_W), .ASID_W(ASID_W)) u_inv (
        .ent_vpn_i (vpn_q[i]),  .ent_block_i (block_q[i]),
        .ent_vmid_i(vmid_q[i]), .ent_asid_i  (asid_q[i]),
        .q_va_i    (inv_va_i),  .q_vmid_i    (inv_vmid_i), .q_asid_i(inv_asid_i),
        .va_hit_o  (iv_va),     .vm_hit_o    (iv_vm),      .as_eq_o (iv_as)
      );

      assign lk_hit[i] = valid_q[i] & lk_va & lk_vm & (lk_as | global_q[i]);

      always_comb begin
        unique case (inv_op)
          INV_ALL:   sel = 1'b1;
          INV_VM:    sel = iv_vm;
          INV_VM_AS: sel = iv_vm & iv_as & ~global_q[i];
          default:   sel = iv_vm & iv_va;
        endcase
      end
      assign inv_kill[i] = inv_valid_i & sel;

      assign pa_cand[i] = block_q[i]
        ? {ppn_q[i][PA_W-1:BLOCK_BITS], lk_va_i[BLOCK_BITS-1:0]}
        : {ppn_q[i], lk_va_i[PAGE_BITS-1:0]};
    end
  endgenerate

  always_comb begin
    pa_sel = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (lk_hit[i]) pa_sel = pa_sel | pa_cand[i];
  end

  // invalidate first, then the refill lands on top
  always_comb begin
    valid_d = valid_q & ~inv_kill;
    if (fill_valid_i) valid_d[victim] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q     <= '0;
      rsp_valid_q <= 1'b0;
      rsp_hit_q   <= 1'b0;
      rsp_miss_q  <= 1'b0;
      rsp_pa_q    <= '0;
      inv_done_q  <= 1'b0;
    end else begin
      valid_q     <= valid_d;
      rsp_valid_q <= lk_valid_i;
      rsp_hit_q   <= lk_valid_i & (|lk_hit);
      rsp_miss_q  <= lk_valid_i & ~(|lk_hit);
      rsp_pa_q    <= lk_valid_i ? pa_sel : '0;
      inv_done_q  <= inv_valid_i;
    end
  end

  always_ff @(posedge clk_i) begin
    if (fill_valid_i) begin
      vpn_q[victim]    <= fill_va_i[VA_W-1:PAGE_BITS];
      ppn_q[victim]    <= fill_pa_i[PA_W-1:PAGE_BITS];
      vmid_q[victim]   <= fill_vmid_i;
      asid_q[victim]   <= fill_asid_i;
      block_q[victim]  <= fill_block_i;
      global_q[victim] <= fill_global_i;
    end
  end

  assign rsp_valid_o = rsp_valid_q;
  assign rsp_hit_o   = rsp_hit_q;
  assign rsp_miss_o  = rsp_miss_q;
  assign rsp_pa_o    = rsp_pa_q;
  assign inv_done_o  = inv_done_q;

  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_valid_i |=> rsp_valid_o); // R2
  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lk_valid_i |=> !rsp_valid_o); // R2
  AST_HIT_XOR_MISS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> (rsp_hit_o ^ rsp_miss_o)); // R2
  AST_QUIET_WHEN_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rsp_valid_o |-> !rsp_hit_o && !rsp_miss_o); // R2
  AST_INV_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inv_valid_i |=> inv_done_o); // R12
  AST_INV_ALL_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inv_valid_i && inv_op_i == 2'b00 && !fill_valid_i |=> valid_q == '0); // R8
  AST_FILL_SURVIVES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_valid_i |=> $countones(valid_q) > 0); // R13
endmodule

// File: tb/vtag_tlb_tb.sv
module vtag_tlb_tb;
  localparam int unsigned ENTRIES = 4;
  localparam int unsigned VA_W = 48, PA_W = 48, VMID_W = 8, ASID_W = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic lk_valid = 0; logic [VA_W-1:0] lk_va = '0;
  logic [VMID_W-1:0] lk_vmid = '0; logic [ASID_W-1:0] lk_asid = '0;
  logic rsp_valid, rsp_hit, rsp_miss; logic [PA_W-1:0] rsp_pa;
  logic fill_valid = 0; logic [VA_W-1:0] fill_va = '0; logic [PA_W-1:0] fill_pa = '0;
  logic [VMID_W-1:0] fill_vmid = '0; logic [ASID_W-1:0] fill_asid = '0;
  logic fill_block = 0, fill_global = 0;
  logic inv_valid = 0; logic [1:0] inv_op = '0;
  logic [VMID_W-1:0] inv_vmid = '0; logic [ASID_W-1:0] inv_asid = '0;
  logic [VA_W-1:0] inv_va = '0;
  logic inv_done;

  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  vtag_tlb #(.ENTRIES(ENTRIES), .VA_W(VA_W), .PA_W(PA_W), .VMID_W(VMID_W), .ASID_W(ASID_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .lk_valid_i(lk_valid), .lk_va_i(lk_va), .lk_vmid_i(lk_vmid), .lk_asid_i(lk_asid),
    .rsp_valid_o(rsp_valid), .rsp_hit_o(rsp_hit), .rsp_miss_o(rsp_miss), .rsp_pa_o(rsp_pa),
    .fill_valid_i(fill_valid), .fill_va_i(fill_va), .fill_pa_i(fill_pa),
    .fill_vmid_i(fill_vmid), .fill_asid_i(fill_asid), .fill_block_i(fill_block),
    .fill_global_i(fill_global),
    .inv_valid_i(inv_valid), .inv_op_i(inv_op), .inv_vmid_i(inv_vmid), .inv_asid_i(inv_asid),
    .inv_va_i(inv_va), .inv_done_o(inv_done)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic set_fill(input logic [VA_W-1:0] va, input logic [PA_W-1:0] pa,
                          input logic [VMID_W-1:0] vm, input logic [ASID_W-1:0] as,
                          input bit blk, input bit glb);
    fill_valid = 1; fill_va = va; fill_pa = pa; fill_vmid = vm; fill_asid = as;
    fill_block = blk; fill_global = glb;
  endtask

  task automatic fill(input logic [VA_W-1:0] va, input logic [PA_W-1:0] pa,
                      input logic [VMID_W-1:0] vm, input logic [ASID_W-1:0] as,
                      input bit blk, input bit glb);
    @(negedge clk); set_fill(va, pa, vm, as, blk, glb);
    @(negedge clk); fill_valid = 0;
  endtask

  task automatic set_inv(input logic [1:0] op, input logic [VMID_W-1:0] vm,
                         input logic [ASID_W-1:0] as, input logic [VA_W-1:0] va);
    inv_valid = 1; inv_op = op; inv_vmid = vm; inv_asid = as; inv_va = va;
  endtask

  task automatic inval(input logic [1:0] op, input logic [VMID_W-1:0] vm,
                       input logic [ASID_W-1:0] as, input logic [VA_W-1:0] va);
    @(negedge clk); set_inv(op, vm, as, va);
    @(negedge clk); inv_valid = 0;
    check(inv_done === 1'b1, "R12 done pulse", 64'(inv_done), 64'd1);
    @(negedge clk);
    check(inv_done === 1'b0, "R12 done drops", 64'(inv_done), 64'd0);
  endtask

  task automatic look(input logic [VA_W-1:0] va, input logic [VMID_W-1:0] vm,
                      input logic [ASID_W-1:0] as, input bit exp_hit,
                      input logic [PA_W-1:0] exp_pa, input string tag);
    @(negedge clk); lk_valid = 1; lk_va = va; lk_vmid = vm; lk_asid = as;
    @(negedge clk); lk_valid = 0;
    check(rsp_valid === 1'b1 && rsp_hit === exp_hit && rsp_miss === !exp_hit,
          {tag, " R2 hit/miss"}, {61'd0, rsp_valid, rsp_hit, rsp_miss},
          {61'd0, 1'b1, exp_hit, !exp_hit});
    if (exp_hit)
      check(rsp_pa === exp_pa, {tag, " pa"}, 64'(rsp_pa), 64'(exp_pa));
  endtask

  function automatic logic [PA_W-1:0] page_pa(input logic [PA_W-1:0] base, input logic [VA_W-1:0] va);
    return (base & ~48'hFFFF) | PA_W'(va & 48'hFFFF);
  endfunction

  function automatic logic [PA_W-1:0] blk_pa(input logic [PA_W-1:0] base, input logic [VA_W-1:0] va);
    return (base & ~48'h1FFF_FFFF) | PA_W'(va & 48'h1FFF_FFFF);
  endfunction

  initial begin
    #(200000 * 4);
    fails++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [15:0] offs [4] = '{16'h0000, 16'h0001, 16'h7FFF, 16'hFFFF};
    logic [VA_W-1:0] pva [5];
    logic [PA_W-1:0] ppa [5];
    for (int i = 0; i < 5; i++) begin
      pva[i] = 48'h0000_1234_0000 + (48'(i) << 16);
      ppa[i] = (48'h800 + 48'(i) * 3) << 16;
    end

    // R1 reset state
    do_reset();
    check(rsp_valid === 1'b0 && inv_done === 1'b0, "R1 reset outputs",
          {62'd0, rsp_valid, inv_done}, 64'd0);
    look(pva[0], 1, 2, 0, '0, "R1 empty");

    // R3 page sweep, R7 fill order
    for (int i = 0; i < 4; i++) fill(pva[i], ppa[i], 1, 2, 0, 0);
    for (int i = 0; i < 4; i++)
      for (int k = 0; k < 4; k++)
        look(pva[i] | 48'(offs[k]), 1, 2, 1, page_pa(ppa[i], 48'(offs[k])), "R3 page");
    look(pva[4], 1, 2, 0, '0, "R3 neighbour page");
    look(pva[1] | 48'h10, 2, 2, 0, '0, "R5 wrong vmid");
    look(pva[1] | 48'h10, 1, 3, 0, '0, "R6 wrong asid");

    // R7 wrap evicts slot 0
    fill(pva[4], ppa[4], 1, 2, 0, 0);
    look(pva[0], 1, 2, 0, '0, "R7 oldest evicted");
    look(pva[4] | 48'h55, 1, 2, 1, page_pa(ppa[4], 48'h55), "R7 new entry");
    look(pva[1], 1, 2, 1, page_pa(ppa[1], 48'h0), "R7 slot1 kept");

    // R4 block, R6 global, R5 vmid on global
    do_reset();
    fill(48'h0000_4000_0000, 48'h00A0_0000_0000, 5, 1, 1, 1);
    for (int k = 0; k < 4; k++) begin
      logic [VA_W-1:0] o;
      o = 48'(k) * 48'h07FF_FFFF + 48'(k);
      look(48'h0000_4000_0000 + o, 5, 8'(9 + k), 1, blk_pa(48'h00A0_0000_0000, o), "R4 R6 block global");
    end
    look(48'h0000_4000_0000 + 48'h1FFF_FFFF, 5, 1, 1,
         blk_pa(48'h00A0_0000_0000, 48'h1FFF_FFFF), "R4 block top");
    look(48'h0000_6000_0000, 5, 1, 0, '0, "R4 next block");
    look(48'h0000_4000_1234, 6, 1, 0, '0, "R5 global other vm");

    // R8..R11 selective invalidates
    do_reset();
    fill(48'h0000_0001_0000, 48'h0011_0000, 1, 1, 0, 0); // A
    fill(48'h0000_0002_0000, 48'h0022_0000, 1, 2, 0, 0); // B
    fill(48'h0000_0003_0000, 48'h0033_0000, 2, 1, 0, 0); // C
    fill(48'h0000_6000_0000, 48'h0000_E000_0000, 1, 3, 1, 1); // D
    inval(2'b10, 1, 3, '0);
    look(48'h0000_6000_0040, 1, 3, 1, 48'h0000_E000_0040, "R10 global kept");
    look(48'h0000_0001_0000, 1, 1, 1, 48'h0011_0000, "R10 other asid kept");
    inval(2'b10, 1, 1, '0);
    look(48'h0000_0001_0000, 1, 1, 0, '0, "R10 vm+as cleared");
    look(48'h0000_0002_0004, 1, 2, 1, 48'h0022_0004, "R10 B kept");
    look(48'h0000_0003_0004, 2, 1, 1, 48'h0033_0004, "R10 C kept");
    inval(2'b11, 2, 0, 48'h0000_6000_1230);
    look(48'h0000_6000_0000, 1, 3, 1, 48'h0000_E000_0000, "R11 other vm kept");
    inval(2'b11, 1, 0, 48'h0000_7FFF_0000);
    look(48'h0000_6000_0000, 1, 3, 0, '0, "R11 block range cleared");
    look(48'h0000_0002_0000, 1, 2, 1, 48'h0022_0000, "R11 page kept");
    inval(2'b01, 2, 0, '0);
    look(48'h0000_0003_0000, 2, 1, 0, '0, "R9 vm cleared");
    look(48'h0000_0002_0000, 1, 2, 1, 48'h0022_0000, "R9 other vm kept");
    inval(2'b00, 0, 0, '0);
    look(48'h0000_0002_0000, 1, 2, 0, '0, "R8 all cleared");

    // R13 refill with invalidate in one cycle
    do_reset();
    @(negedge clk);
    set_fill(48'h0000_0009_0000, 48'h0099_0000, 7, 1, 0, 0);
    set_inv(2'b00, 0, 0, '0);
    @(negedge clk); fill_valid = 0; inv_valid = 0;
    look(48'h0000_0009_0001, 7, 1, 1, 48'h0099_0001, "R13 fill after inv all");
    @(negedge clk);
    set_fill(48'h0000_000A_0000, 48'h00AA_0000, 7, 1, 0, 0);
    set_inv(2'b01, 7, 0, '0);
    @(negedge clk); fill_valid = 0; inv_valid = 0;
    look(48'h0000_000A_0002, 7, 1, 1, 48'h00AA_0002, "R13 fill after inv vm");
    look(48'h0000_0009_0001, 7, 1, 0, '0, "R13 older entry cleared");

    // R14 lookup sees pre-update state
    @(negedge clk);
    lk_valid = 1; lk_va = 48'h0000_000A_0003; lk_vmid = 7; lk_asid = 1;
    set_inv(2'b00, 0, 0, '0);
    @(negedge clk); lk_valid = 0; inv_valid = 0;
    check(rsp_hit === 1'b1 && rsp_pa === 48'h00AA_0003, "R14 lookup with inv",
          64'(rsp_pa), 64'h00AA_0003);
    look(48'h0000_000A_0003, 7, 1, 0, '0, "R14 after inv");
    @(negedge clk);
    lk_valid = 1; lk_va = 48'h0000_000B_0000; lk_vmid = 7; lk_asid = 1;
    set_fill(48'h0000_000B_0000, 48'h00BB_0000, 7, 1, 0, 0);
    @(negedge clk); lk_valid = 0; fill_valid = 0;
    check(rsp_miss === 1'b1, "R14 lookup with fill", 64'(rsp_miss), 64'd1);
    look(48'h0000_000B_0000, 7, 1, 1, 48'h00BB_0000, "R14 after fill");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule